// File: doc/BRIEF.md
# Carry-Save 4x4 Array Multiplier

This block forms the unsigned product of two 4-bit operands in a single combinational path. It is built as an explicit gate-level array and not written as a multiply operator. A 4x4 grid of two-input AND gates creates the partial-product bits. Partial-product row `j` is a copy of the multiplicand shifted `j` places left when multiplier bit `j` is 1, and it is all zeros when that bit is 0.

Three unrolled adder rows reduce the partial products. Each summing cell sends its carry diagonally into the next more-significant column of the following row, so no carry travels sideways inside a reduction row. A closing merge row then resolves the carries that remain. The array holds exactly 16 AND gates, 4 half adders and 8 full adders. Half adders appear only where a column has two bits and no incoming carry.

The block has no clock or reset. An integrator places it between registers of their own and budgets its delay as one combinational stage.

Top module: `csa_mul4x4`

## Requirements
- R1: For every one of the 256 operand pairs, `prod_o` equals the unsigned product of `mcand_i` and `mplier_i` as an 8-bit value, bit 0 least significant.
- R2: When either operand is zero, `prod_o` is zero.
- R3: When either operand is one, `prod_o` equals the other operand zero-extended to 8 bits.
- R4: Swapping the two operands leaves `prod_o` unchanged.
- R5: With `mcand_i` = 4'b1100 and `mplier_i` = 4'b1001, `prod_o` is 8'b01101100.
- R6: `prod_o[0]` is the AND of `mcand_i[0]` and `mplier_i[0]`, with no adder on that path.
- R7: Partial-product row `j` equals the multiplicand when `mplier_i[j]` is 1 and is zero otherwise. So a one-hot multiplier `1<<j` gives `prod_o` = `mcand_i << j`.
- R8: Every half-adder cell returns the 2-bit count of its two inputs, and every full-adder cell returns the 2-bit count of its three inputs, as {carry, sum}.
- R9: The largest operands (15 x 15) give 8'b11100001, so the closing carry-out drives `prod_o[7]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 4 | Unsigned multiplicand |
| mplier_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product |

## Verification
The embedded checks are immediate assertions evaluated whenever the operands change. They assume both operands are driven to known 0/1 values and held steady long enough for the array to settle. The stimulus changes operands only on one clock edge and samples on the opposite edge, so every check sees a settled array. Beyond the exhaustive sweep, the stimulus also reapplies every pair with the operands swapped, and it adds seeded random pairs and one-hot multipliers, so that each cell's carry path is exercised from several directions.

// File: rtl/csa_mul_pkg.sv
// Shared sizing for the carry-save 4x4 multiplier.
// Assumes the array is wired for exactly four operand bits.
package csa_mul_pkg;
    localparam int OP_W   = 4;
    localparam int PROD_W = 2 * OP_W;
endpackage

// File: rtl/csa_half_adder.sv
// Half-adder cell: adds two bits into {carry, sum}.
// Assumes known 0/1 inputs; purely combinational.
module csa_half_adder (
    input  logic a_i,
    input  logic b_i,
    output logic sum_o,
    output logic cy_o
);
    // Gate-level sum and carry.
    assign sum_o = a_i ^ b_i;
    assign cy_o  = a_i & b_i;

    // Cell output must be the arithmetic count of its inputs.
    always_comb begin
        AST_HA_COUNT: assert ({cy_o, sum_o} == (2'(a_i) + 2'(b_i))); // R8
    end
endmodule

// File: rtl/csa_full_adder.sv
// Full-adder cell: adds three bits into {carry, sum}.
// Assumes known 0/1 inputs; purely combinational.
module csa_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic sum_o,
    output logic cy_o
);
    logic half_x;

    // Two-level XOR for sum, majority via propagate term for carry.
    assign half_x = a_i ^ b_i;
    assign sum_o  = half_x ^ c_i;
    assign cy_o   = (a_i & b_i) | (c_i & half_x);

    // Cell output must be the arithmetic count of its inputs.
    always_comb begin
        AST_FA_COUNT: assert ({cy_o, sum_o} == (2'(a_i) + 2'(b_i) + 2'(c_i))); // R8
    end
endmodule

// File: rtl/csa_pp_grid.sv
// Partial-product grid: pp_o[j][i] = multiplicand bit i gated by multiplier bit j.
// Assumes square operands of OP_W bits; one two-input AND per grid point.
module csa_pp_grid #(
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0]           mcand_i,
    input  logic [OP_W-1:0]           mplier_i,
    output logic [OP_W-1:0][OP_W-1:0] pp_o
);
    for (genvar j = 0; j < OP_W; j++) begin : g_row
        for (genvar i = 0; i < OP_W; i++) begin : g_col
            // One AND gate per partial-product bit.
            assign pp_o[j][i] = mcand_i[i] & mplier_i[j];
        end

        // A row is either the whole multiplicand or nothing.
        always_comb begin
            if (mplier_i[j]) begin
                AST_ROW_SELECT: assert (pp_o[j] == mcand_i); // R7
            end else begin
                AST_ROW_ZERO: assert (pp_o[j] == '0); // R7
            end
        end
    end
endmodule

// File: rtl/csa_mul4x4.sv
// Unsigned 4x4 array multiplier, carry-save reduction plus a merge row.
// Assumes settled 0/1 operands; no clock or reset, one combinational stage.
// Cell budget: 16 AND, 4 half adders, 8 full adders. Carries of each
// reduction row go diagonally to column k+1 of the next row.
module csa_mul4x4
    import csa_mul_pkg::*;
(
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic [PROD_W-1:0] prod_o
);
    logic [OP_W-1:0][OP_W-1:0] pp;
    logic [3:1] r1_s, r1_c;   // row 1, columns 1..3
    logic [4:2] r2_s, r2_c;   // row 2, columns 2..4
    logic [5:3] r3_s, r3_c;   // row 3, columns 3..5
    logic       m4_c, m5_c;   // merge-row carries

    csa_pp_grid #(.OP_W(OP_W)) i_grid (
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .pp_o     (pp)
    );

    // Row 1: pairs of partial products, no carry in, so half adders.
    for (genvar k = 1; k <= 3; k++) begin : g_r1
        csa_half_adder i_ha (
            .a_i   (pp[0][k]),
            .b_i   (pp[1][k-1]),
            .sum_o (r1_s[k]),
            .cy_o  (r1_c[k])
        );
    end

    // Row 2: fold in multiplier bit 2 with row-1 carries from column k-1.
    for (genvar k = 2; k <= 4; k++) begin : g_r2
        logic upper;
        if (k < 4) begin : g_mid
            assign upper = r1_s[k];
        end else begin : g_top
            assign upper = pp[1][3];
        end
        csa_full_adder i_fa (
            .a_i   (upper),
            .b_i   (pp[2][k-2]),
            .c_i   (r1_c[k-1]),
            .sum_o (r2_s[k]),
            .cy_o  (r2_c[k])
        );
    end

    // Row 3: fold in multiplier bit 3 with row-2 carries from column k-1.
    for (genvar k = 3; k <= 5; k++) begin : g_r3
        logic upper;
        if (k < 5) begin : g_mid
            assign upper = r2_s[k];
        end else begin : g_top
            assign upper = pp[2][3];
        end
        csa_full_adder i_fa (
            .a_i   (upper),
            .b_i   (pp[3][k-3]),
            .c_i   (r2_c[k-1]),
            .sum_o (r3_s[k]),
            .cy_o  (r3_c[k])
        );
    end

    // Merge row: short ripple resolving the saved carries of row 3.
    csa_half_adder i_m4 (
        .a_i   (r3_s[4]),
        .b_i   (r3_c[3]),
        .sum_o (prod_o[4]),
        .cy_o  (m4_c)
    );
    csa_full_adder i_m5 (
        .a_i   (r3_s[5]),
        .b_i   (r3_c[4]),
        .c_i   (m4_c),
        .sum_o (prod_o[5]),
        .cy_o  (m5_c)
    );
    csa_full_adder i_m6 (
        .a_i   (pp[3][3]),
        .b_i   (r3_c[5]),
        .c_i   (m5_c),
        .sum_o (prod_o[6]),
        .cy_o  (prod_o[7])
    );

    // Low product bits leave the array as soon as their column is complete.
    assign prod_o[0] = pp[0][0];
    assign prod_o[1] = r1_s[1];
    assign prod_o[2] = r2_s[2];
    assign prod_o[3] = r3_s[3];

    // Port-level checks of the assembled array.
    always_comb begin
        AST_PRODUCT_VALUE: assert (prod_o == PROD_W'(mcand_i) * PROD_W'(mplier_i)); // R1
        if (mcand_i == '0 || mplier_i == '0) begin
            AST_ZERO_OPERAND: assert (prod_o == '0); // R2
        end
        if (mplier_i == OP_W'(1)) begin
            AST_UNIT_OPERAND: assert (prod_o == PROD_W'(mcand_i)); // R3
        end
        AST_LSB_PATH: assert (prod_o[0] == (mcand_i[0] & mplier_i[0])); // R6
    end
endmodule

// File: tb/test_csa_mul4x4.sv
// Bench: exhaustive sweep, swapped sweep, seeded random and directed corners.
module test_csa_mul4x4;
    logic       clk = 1'b0;
    logic [3:0] mcand = '0;
    logic [3:0] mplier = '0;
    logic [7:0] prod;
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    csa_mul4x4 i_csa_mul4x4 (
        .mcand_i  (mcand),
        .mplier_i (mplier),
        .prod_o   (prod)
    );

    function automatic logic [7:0] ref_prod(input logic [3:0] x, input logic [3:0] y);
        int acc = 0;
        for (int j = 0; j < 4; j++) begin
            if (y[j]) acc += int'(x) << j;
        end
        return acc[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s a=%0d b=%0d actual=%b expected=%b", req, mcand, mplier, act, exp_v);
        end
    endtask

    // Drive on the rising edge, sample settled outputs on the falling edge.
    task automatic apply(input logic [3:0] x, input logic [3:0] y);
        @(posedge clk);
        mcand  = x;
        mplier = y;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] first;
        logic [3:0] ra, rb;
        void'($urandom(32'h00C5A1E5));
        @(negedge clk);
        check("R2 idle", prod, 8'h00);

        apply(4'b1100, 4'b1001);
        check("R5", prod, 8'b01101100);
        apply(4'hF, 4'hF);
        check("R9", prod, 8'b11100001);

        for (int x = 0; x < 16; x++) begin
            apply(4'(x), 4'd0);  check("R2", prod, 8'h00);
            apply(4'd0, 4'(x));  check("R2", prod, 8'h00);
            apply(4'(x), 4'd1);  check("R3", prod, 8'(x));
            apply(4'd1, 4'(x));  check("R3", prod, 8'(x));
            for (int j = 0; j < 4; j++) begin
                apply(4'(x), 4'(1 << j));
                check("R7", prod, 8'(x << j));
            end
            apply(4'(x), 4'(x));
            check("R6", {7'd0, prod[0]}, {7'd0, 1'(x & 1)});
        end

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(4'(x), 4'(y));
                check("R1", prod, ref_prod(4'(x), 4'(y)));
                first = prod;
                apply(4'(y), 4'(x));
                check("R4", prod, first);
            end
        end

        for (int n = 0; n < 300; n++) begin
            ra = 4'($urandom);
            rb = 4'($urandom);
            apply(ra, rb);
            check("R1 rnd", prod, ref_prod(ra, rb));
            check("R8 rnd", prod, 8'(int'(ra) * int'(rb)));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule